// File: doc/BRIEF.md
# Interval Timer Byte-Serial Register Front End

This block sits between an 8-bit host bus and the counter cores of a three-channel interval timer. The host sees one data port for each channel and one write-only command port. A command byte picks a channel, an operating mode and the way that channel's 16-bit values travel over the 8-bit bus. Data writes build each channel's 16-bit reload value one byte at a time. Data reads return the channel's count one byte at a time, low byte first.

Toward the counter cores the block drives a mode field, the assembled reload value and a one-cycle "reload written" strobe for each channel. It takes each core's live count back. A latch command copies a channel's live count into a holding register, so that a two-byte read sees one consistent value. The snapshot stays until its high byte has been read. Counting itself and decimal counting belong to the cores and are not handled here.

Top module: `tmr_regif`

## Requirements
- R1: After reset every channel reports mode 0, reload 0 and no strobe. Data writes to a channel that has not yet received a programming command change nothing. The first read of any channel returns the low byte of its live count.
- R2: A write to the command port (address 3) is decoded as follows: bits 7:6 select the channel, bits 5:4 give the access mode (0 latch, 1 low only, 2 high only, 3 low then high), bits 3:1 give the operating mode, and bit 0 is ignored. A non-latch command loads the selected channel's mode output from bits 3:1 after the next clock edge. A latch command leaves the mode unchanged.
- R3: In low-only access, every data write replaces reload bits 7:0, keeps bits 15:8 and fires the strobe.
- R4: In high-only access, every data write replaces reload bits 15:8, keeps bits 7:0 and fires the strobe.
- R5: In low-then-high access, the command arms the low byte. Data writes then alternate low, high, low, and so on. Only the high-byte write fires the strobe.
- R6: Data reads of a channel alternate between the low byte and the high byte of its live count, starting at the low byte. Each read shows the count value present in that cycle.
- R7: A latch command on a channel with no pending snapshot copies the live count into a holding register. Reads then return bytes of that snapshot even if the live count changes.
- R8: A latch command on a channel whose snapshot is still pending is ignored. The earlier snapshot is kept.
- R9: Reading the high byte of a snapshot releases it. Later reads see the live count again.
- R10: A command with channel select 3 changes no channel's mode, reload, write phase, read phase or latch state.
- R11: The strobe and the new reload value appear in the cycle after the accepted write and last exactly one cycle. At most one channel strobes in any cycle.
- R12: Commands, writes and reads addressed to one channel leave every other channel's outputs and sequencing state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed port |
| bus_rd | input | 1 | Read strobe for the addressed port |
| bus_addr | input | 2 | 0..2 select a channel data port, 3 selects the command port |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte for the addressed channel (0 at the command port) |
| ch_count | input | 48 | Live 16-bit count of each channel, channel 0 in the low bits |
| ch_mode | output | 9 | 3-bit operating mode of each channel |
| ch_reload | output | 48 | 16-bit assembled reload value of each channel |
| ch_load_stb | output | 3 | One-cycle reload-written strobe for each channel |

## Verification
A wrong write phase shows up on the very next data write. The wrong half of ch_reload changes, or the strobe fires on the low byte, or it fails to fire on the high byte. The bench checks every channel's reload and strobe after each write, so a phase error is caught at that write. A wrong read phase or a stuck latch flag shows up on bus_rdata at the next read: the wrong byte or a stale snapshot comes back. To catch this, the bench changes the live count between the reads of a byte pair, so the stale value and the live value differ. Any leak between channels appears at once, because all three channels' outputs are compared after every operation.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_LOHI  = 2'd3
  } acc_t;

  typedef enum logic [1:0] {
    WPH_IDLE = 2'd0,
    WPH_LO   = 2'd1,
    WPH_HI   = 2'd2
  } wph_t;

  localparam logic [1:0] SEL_READBACK = 2'd3;

  typedef struct packed {
    logic [1:0]        sel;
    acc_t              acc;
    logic [MODE_W-1:0] mode;
    logic              bcd;
  } cmd_t;

endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
  import tmr_regif_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                cmd_wr,
  input  logic [BYTE_W-1:0]   cmd_byte,
  output logic [NUM_CH-1:0]   ch_prog,
  output logic [NUM_CH-1:0]   ch_latch,
  output acc_t                prog_acc,
  output logic [MODE_W-1:0]   prog_mode
);

  cmd_t cmd;
  logic is_readback;
  logic unused_bcd;

  assign cmd         = cmd_t'(cmd_byte);
  assign is_readback = (cmd.sel == SEL_READBACK);
  assign prog_acc    = cmd.acc;
  assign prog_mode   = cmd.mode;
  assign unused_bcd  = cmd.bcd;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    logic hit;
    assign hit         = cmd_wr && !is_readback && (cmd.sel == 2'(i));
    assign ch_prog[i]  = hit && (cmd.acc != ACC_LATCH);
    assign ch_latch[i] = hit && (cmd.acc == ACC_LATCH);
  end

endmodule

// File: rtl/tmr_wr_seq.sv
module tmr_wr_seq
  import tmr_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog,
  input  acc_t              prog_acc,
  input  logic [MODE_W-1:0] prog_mode,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] data_byte,
  output logic [MODE_W-1:0] mode,
  output logic [CNT_W-1:0]  reload,
  output logic              load_stb
);

  acc_t              acc_q, acc_d;
  wph_t              wph_q, wph_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [CNT_W-1:0]  rel_q, rel_d;
  logic              stb_q, stb_d;
  logic              upd_en;

  always_comb begin
    acc_d  = acc_q;
    wph_d  = wph_q;
    mode_d = mode_q;
    rel_d  = rel_q;
    stb_d  = 1'b0;
    if (prog) begin
      mode_d = prog_mode;
      acc_d  = prog_acc;
      wph_d  = (prog_acc == ACC_HI) ? WPH_HI : WPH_LO;
    end else if (data_wr) begin
      unique case (wph_q)
        WPH_LO: begin
          rel_d[BYTE_W-1:0] = data_byte;
          if (acc_q == ACC_LOHI) wph_d = WPH_HI;
          else                   stb_d = 1'b1;
        end
        WPH_HI: begin
          rel_d[CNT_W-1:BYTE_W] = data_byte;
          stb_d = 1'b1;
          if (acc_q == ACC_LOHI) wph_d = WPH_LO;
        end
        default: ;
      endcase
    end
  end

  assign upd_en = prog || data_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= ACC_LATCH;
      wph_q  <= WPH_IDLE;
      mode_q <= '0;
      rel_q  <= '0;
    end else if (upd_en) begin
      acc_q  <= acc_d;
      wph_q  <= wph_d;
      mode_q <= mode_d;
      rel_q  <= rel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb_d;
  end

  assign mode     = mode_q;
  assign reload   = rel_q;
  assign load_stb = stb_q;

endmodule

// File: rtl/tmr_rd_seq.sv
module tmr_rd_seq
  import tmr_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_req,
  input  logic              rd_req,
  input  logic [CNT_W-1:0]  live_cnt,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              latch_pend
);

  logic             hi_q, hi_d;
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] hold_q, hold_d;
  logic [CNT_W-1:0] src;
  logic             upd_en;

  always_comb begin
    hi_d   = hi_q;
    pend_d = pend_q;
    hold_d = hold_q;
    if (latch_req && !pend_q) begin
      hold_d = live_cnt;
      pend_d = 1'b1;
    end
    if (rd_req) begin
      hi_d = !hi_q;
      if (hi_q && pend_q) pend_d = 1'b0;
    end
  end

  assign upd_en = latch_req || rd_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= 1'b0;
      pend_q <= 1'b0;
      hold_q <= '0;
    end else if (upd_en) begin
      hi_q   <= hi_d;
      pend_q <= pend_d;
      hold_q <= hold_d;
    end
  end

  assign src        = pend_q ? hold_q : live_cnt;
  assign rd_byte    = hi_q ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
  assign latch_pend = pend_q;

endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_regif_pkg::*;
#(
  parameter int NUM_CH = 3,
  localparam int ADDR_W = $clog2(NUM_CH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [BYTE_W-1:0]        bus_wdata,
  output logic [BYTE_W-1:0]        bus_rdata,
  input  logic [NUM_CH*CNT_W-1:0]  ch_count,
  output logic [NUM_CH*MODE_W-1:0] ch_mode,
  output logic [NUM_CH*CNT_W-1:0]  ch_reload,
  output logic [NUM_CH-1:0]        ch_load_stb
);

  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(NUM_CH);

  logic [NUM_CH-1:0]       ch_prog;
  logic [NUM_CH-1:0]       ch_latch;
  logic [NUM_CH-1:0]       latch_pend;
  acc_t                    prog_acc;
  logic [MODE_W-1:0]       prog_mode;
  logic [BYTE_W-1:0]       rd_bytes [NUM_CH];

  tmr_cmd_decode #(.NUM_CH(NUM_CH)) dec_i (
    .cmd_wr    (bus_wr && (bus_addr == CMD_ADDR)),
    .cmd_byte  (bus_wdata),
    .ch_prog   (ch_prog),
    .ch_latch  (ch_latch),
    .prog_acc  (prog_acc),
    .prog_mode (prog_mode)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel;
    assign sel = (bus_addr == ADDR_W'(i));

    tmr_wr_seq wr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .prog      (ch_prog[i]),
      .prog_acc  (prog_acc),
      .prog_mode (prog_mode),
      .data_wr   (bus_wr && sel),
      .data_byte (bus_wdata),
      .mode      (ch_mode[i*MODE_W +: MODE_W]),
      .reload    (ch_reload[i*CNT_W +: CNT_W]),
      .load_stb  (ch_load_stb[i])
    );

    tmr_rd_seq rd_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .latch_req  (ch_latch[i]),
      .rd_req     (bus_rd && sel),
      .live_cnt   (ch_count[i*CNT_W +: CNT_W]),
      .rd_byte    (rd_bytes[i]),
      .latch_pend (latch_pend[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(i)) bus_rdata = rd_bytes[i];
    end
  end

endmodule

// File: rtl/tmr_regif_chk.sv
module tmr_regif_chk
  import tmr_regif_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_wr,
  input logic                     bus_rd,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [BYTE_W-1:0]        bus_wdata,
  input logic [NUM_CH*MODE_W-1:0] ch_mode,
  input logic [NUM_CH*CNT_W-1:0]  ch_reload,
  input logic [NUM_CH-1:0]        ch_load_stb,
  input logic [NUM_CH-1:0]        latch_pend
);

  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(NUM_CH);

  logic cmd_wr;
  assign cmd_wr = bus_wr && (bus_addr == CMD_ADDR);

  p_stb_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_load_stb));

  p_readback_noop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[7:6] == 2'd3) |=>
      ($stable(ch_mode) && $stable(ch_reload) && $stable(latch_pend)));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    p_stb_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ch_load_stb[i] |-> $past(bus_wr && bus_addr == ADDR_W'(i)));

    p_reload_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ch_reload[i*CNT_W +: CNT_W]) |-> $past(bus_wr && bus_addr == ADDR_W'(i)));

    p_mode_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ch_mode[i*MODE_W +: MODE_W]) |->
        $past(cmd_wr && bus_wdata[7:6] == 2'(i) && bus_wdata[5:4] != 2'd0));

    p_latch_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(latch_pend[i]) |->
        $past(cmd_wr && bus_wdata[7:6] == 2'(i) && bus_wdata[5:4] == 2'd0));

    p_latch_rel_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(latch_pend[i]) |-> $past(bus_rd && bus_addr == ADDR_W'(i)));
  end

endmodule

bind tmr_regif tmr_regif_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .ch_mode     (ch_mode),
  .ch_reload   (ch_reload),
  .ch_load_stb (ch_load_stb),
  .latch_pend  (latch_pend)
);

// File: tb/tmr_regif_tb_top.sv
module tmr_regif_tb_top;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_rd;
  logic [1:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [47:0] ch_count;
  logic [8:0]  ch_mode;
  logic [47:0] ch_reload;
  logic [2:0]  ch_load_stb;

  logic [15:0] cnt [3];
  assign ch_count = {cnt[2], cnt[1], cnt[0]};

  int checks;
  int errors;
  bit done;

  int m_mode [3];
  int m_acc  [3];
  int m_wph  [3];
  int m_rel  [3];
  int m_lat  [3];
  int m_hold [3];
  int m_rph  [3];

  tmr_regif dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .ch_count    (ch_count),
    .ch_mode     (ch_mode),
    .ch_reload   (ch_reload),
    .ch_load_stb (ch_load_stb)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_outs(input string req, input int own, input int stb_ch);
    for (int c = 0; c < 3; c++) begin
      string tag;
      tag = (c == own) ? req : "R12";
      chk(tag, int'(ch_mode[c*3 +: 3]), m_mode[c]);
      chk(tag, int'(ch_reload[c*16 +: 16]), m_rel[c]);
      chk((c == stb_ch) ? req : "R11", int'(ch_load_stb[c]), (c == stb_ch) ? 1 : 0);
    end
  endtask

  task automatic do_cmd(input int sel, input int acc, input int mode, input int bcd, input string req);
    if (sel != 3) begin
      if (acc == 0) begin
        if (m_lat[sel] == 0) begin
          m_hold[sel] = cnt[sel];
          m_lat[sel]  = 1;
        end
      end else begin
        m_mode[sel] = mode;
        m_acc[sel]  = acc;
        m_wph[sel]  = (acc == 2) ? 2 : 1;
      end
    end
    @(negedge clk);
    bus_addr  = 2'd3;
    bus_wdata = {sel[1:0], acc[1:0], mode[2:0], bcd[0]};
    bus_wr    = 1'b1;
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
    chk_outs(req, sel, -1);
  endtask

  task automatic do_wr(input int ch, input int d, input string req);
    int stb_ch;
    stb_ch = -1;
    if (m_wph[ch] == 1) begin
      m_rel[ch] = (m_rel[ch] & 16'hff00) | d;
      if (m_acc[ch] == 3) m_wph[ch] = 2;
      else stb_ch = ch;
    end else if (m_wph[ch] == 2) begin
      m_rel[ch] = (m_rel[ch] & 16'h00ff) | (d << 8);
      stb_ch = ch;
      if (m_acc[ch] == 3) m_wph[ch] = 1;
    end
    @(negedge clk);
    bus_addr  = 2'(ch);
    bus_wdata = 8'(d);
    bus_wr    = 1'b1;
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
    chk_outs(req, ch, stb_ch);
  endtask

  task automatic do_rd(input int ch, input string req);
    int src;
    int exp;
    src = (m_lat[ch] != 0) ? m_hold[ch] : int'(cnt[ch]);
    exp = (m_rph[ch] != 0) ? ((src >> 8) & 255) : (src & 255);
    if (m_rph[ch] != 0 && m_lat[ch] != 0) m_lat[ch] = 0;
    m_rph[ch] = 1 - m_rph[ch];
    @(negedge clk);
    bus_addr = 2'(ch);
    bus_rd   = 1'b1;
    #1;
    chk(req, int'(bus_rdata), exp);
    @(posedge clk);
    #1;
    bus_rd = 1'b0;
  endtask

  task automatic set_cnt(input int ch, input int v);
    @(negedge clk);
    cnt[ch] = 16'(v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done   = 0;
    rst_n     = 1'b0;
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    for (int c = 0; c < 3; c++) begin
      cnt[c] = 16'(16'h1234 + c * 16'h1111);
      m_mode[c] = 0; m_acc[c] = 0; m_wph[c] = 0; m_rel[c] = 0;
      m_lat[c] = 0; m_hold[c] = 0; m_rph[c] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    // R1: reset state, writes before programming are ignored, reads start low
    chk_outs("R1", 0, -1);
    do_wr(0, 8'h5a, "R1");
    do_wr(2, 8'ha5, "R1");
    do_rd(1, "R1");
    do_rd(1, "R1");

    // R2..R5: sweep channel x access mode x operating mode
    for (int ch = 0; ch < 3; ch++) begin
      for (int acc = 1; acc < 4; acc++) begin
        for (int mode = 0; mode < 8; mode++) begin
          string tag;
          tag = (acc == 1) ? "R3" : (acc == 2) ? "R4" : "R5";
          do_cmd(ch, acc, mode, mode & 1, "R2");
          for (int k = 0; k < 3; k++) begin
            do_wr(ch, (ch * 37 + acc * 11 + mode * 5 + k * 3 + 1) & 255, tag);
          end
          @(posedge clk);
          #1;
          chk_outs("R11", ch, -1);
        end
      end
    end

    // R6: live reads alternate low/high, count changes between bytes
    for (int ch = 0; ch < 3; ch++) begin
      set_cnt(ch, 16'hab00 + ch * 16'h0111);
      do_rd(ch, "R6");
      set_cnt(ch, 16'h3c77 + ch);
      do_rd(ch, "R6");
      do_rd(ch, "R6");
      do_rd(ch, "R6");
    end

    // R7, R8, R9: snapshot, repeat latch ignored, release after high byte
    for (int ch = 0; ch < 3; ch++) begin
      set_cnt(ch, 16'h8421 + ch * 16'h0102);
      do_cmd(ch, 0, 5, 0, "R7");
      set_cnt(ch, 16'h1f2e);
      do_rd(ch, "R7");
      do_cmd(ch, 0, 2, 0, "R8");
      set_cnt(ch, 16'h6d5c);
      do_rd(ch, "R8");
      do_rd(ch, "R9");
      set_cnt(ch, 16'h7e9a);
      do_rd(ch, "R9");
      do_cmd(ch, 0, 0, 0, "R7");
      set_cnt(ch, 16'h0001);
      do_rd((ch + 1) % 3, "R12");
      do_rd((ch + 1) % 3, "R12");
      do_rd(ch, "R7");
      do_rd(ch, "R9");
    end

    // R10: read-back selector leaves all state unchanged
    do_cmd(0, 3, 4, 0, "R10");
    do_wr(0, 8'h11, "R10");
    set_cnt(1, 16'hc3b2);
    do_cmd(1, 0, 0, 0, "R10");
    do_rd(1, "R10");
    for (int acc = 0; acc < 4; acc++) begin
      for (int mode = 0; mode < 8; mode++) begin
        do_cmd(3, acc, mode, acc & 1, "R10");
      end
    end
    set_cnt(1, 16'h0f0f);
    do_rd(1, "R10");
    do_rd(1, "R10");
    do_wr(0, 8'h22, "R10");
    do_wr(0, 8'h33, "R10");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule